// File: doc/BRIEF.md
# Wide-Dividend Unsigned Divider with Remainder

This unit performs unsigned division of a double-width dividend by a single-width divisor. The dividend is formed by placing operand `a_i` in the upper word and `c_i` in the lower word. The divisor is `b_i`. One transaction returns both a single-width quotient and a single-width remainder. The intended use is the inner step of arbitrary-precision division: the remainder goes back to the register that supplied the low word, and it feeds the next limb.

A quotient that would not fit in one word is flagged as an error. A zero divisor is also an error. In both cases the unit returns a fixed pattern: the quotient is all ones, the remainder is zero, and `ovf_o` is set. No output is ever undefined. The error check happens in the cycle after the operands are accepted, and an error result skips the iterative loop. A valid result takes one restoring shift-and-subtract step per quotient bit.

Operands enter through a valid/ready handshake. Results leave through a second valid/ready handshake. The unit holds one operation at a time.

Top module: `qd_divider`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0.
- R2: Operands are taken on a clock edge where in_valid_i and in_ready_o are both 1. From that edge until the result is taken, in_ready_o is 0.
- R3: When a_i < b_i (unsigned) and b_i is not 0, q_o equals floor({a_i,c_i} / b_i) and r_o equals {a_i,c_i} mod b_i.
- R4: When a_i >= b_i, q_o is all ones, r_o is 0 and ovf_o is 1.
- R5: When b_i is 0, the result is the same error pattern as in R4, whatever the values of a_i and c_i.
- R6: For a valid result, ovf_o is 0 and r_o < b_i.
- R7: An error result raises out_valid_o exactly 1 clock edge after the accepting edge.
- R8: A valid result raises out_valid_o exactly W+1 clock edges after the accepting edge (65 for W=64).
- R9: While out_valid_o is 1 and out_ready_i is 0, q_o, r_o and ovf_o hold their values and out_valid_o stays 1.
- R10: Operands presented with in_valid_i while the unit is busy are ignored, and the pending result is unchanged.
- R11: Division inverts multiply-add. For any q, b and r with r < b and b not 0, dividing the high and low words of q*b + r by b returns q and r.
- R12: On the edge after out_valid_o and out_ready_i are both 1, out_valid_o falls and in_ready_o rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid |
| in_ready_o | output | 1 | Unit can take operands |
| a_i | input | W | Upper word of dividend |
| b_i | input | W | Divisor |
| c_i | input | W | Lower word of dividend |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes result |
| q_o | output | W | Quotient |
| r_o | output | W | Remainder |
| ovf_o | output | 1 | Error result (quotient too wide or divisor zero) |

## Verification
Directed operands cover several cases:
- b = 1, which must return c unchanged with a zero remainder.
- a = b-1 with c all ones, the largest quotient that still fits.
- An all-ones divisor.
- A mid-range case.

Each of these exercises the extremes of the subtract decision at every step.

The error cases are tested separately:
- a equal to b.
- a above b.
- b = 0 with both a zero and a non-zero.

These separate the boundary of the comparison from the divide-by-zero check, and they confirm the short latency.

Random multiply-add inversions use both small and full-width divisors to show that quotient bits and remainder agree with the arithmetic identity. Backpressure and mid-operation input pokes separate correct holding from leakage of new operands.

// File: rtl/qd_div_pkg.sv
package qd_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } qd_state_e;
endpackage

// File: rtl/qd_div_step.sv
// One restoring step: shift in next dividend bit, subtract divisor if it fits.
module qd_div_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic         bit_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] rem_o,
  output logic         qbit_o
);
  logic [W:0] trial;
  logic [W:0] diff;

  always_comb begin
    trial  = {rem_i, bit_i};
    diff   = trial - {1'b0, div_i};
    qbit_o = (trial >= {1'b0, div_i});
    rem_o  = qbit_o ? diff[W-1:0] : trial[W-1:0];
  end
endmodule

// File: rtl/qd_div_ctrl.sv
module qd_div_ctrl
  import qd_div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic out_ready_i,
  input  logic err_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic load_o,
  output logic chk_o,
  output logic step_o
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  qd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  assign in_ready_o  = (state_q == ST_IDLE);
  assign out_valid_o = (state_q == ST_DONE);
  assign load_o      = in_ready_o && in_valid_i;
  assign chk_o       = (state_q == ST_CHECK);
  assign step_o      = (state_q == ST_RUN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (in_valid_i) state_d = ST_CHECK;
      ST_CHECK: state_d = err_i ? ST_DONE : ST_RUN;
      ST_RUN:   if (cnt_q == LAST) state_d = ST_DONE;
      ST_DONE:  if (out_ready_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (chk_o)       cnt_q <= '0;
      else if (step_o) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/qd_div_datapath.sv
module qd_div_datapath #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         chk_i,
  input  logic         step_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic         err_o,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o,
  output logic         ovf_o
);
  logic [W-1:0] rem_q, quo_q, div_q;
  logic         ovf_q;
  logic [W-1:0] rem_n;
  logic         qbit;

  // rem_q holds the upper dividend word until the check cycle
  assign err_o = (div_q == '0) || (rem_q >= div_q);

  qd_div_step #(.W(W)) u_step (
    .rem_i  (rem_q),
    .bit_i  (quo_q[W-1]),
    .div_i  (div_q),
    .rem_o  (rem_n),
    .qbit_o (qbit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
      ovf_q <= 1'b0;
    end else if (load_i) begin
      rem_q <= a_i;
      quo_q <= c_i;
      div_q <= b_i;
      ovf_q <= 1'b0;
    end else if (chk_i) begin
      if (err_o) begin
        rem_q <= '0;
        quo_q <= '1;
        ovf_q <= 1'b1;
      end
    end else if (step_i) begin
      rem_q <= rem_n;
      quo_q <= {quo_q[W-2:0], qbit};
    end
  end

  assign q_o   = quo_q;
  assign r_o   = rem_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/qd_divider.sv
module qd_divider #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] r_o,
  output logic         ovf_o
);
  logic load, chk, step, err;

  qd_div_ctrl #(.W(W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .err_i       (err),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .load_o      (load),
    .chk_o       (chk),
    .step_o      (step)
  );

  qd_div_datapath #(.W(W)) u_dp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .chk_i  (chk),
    .step_i (step),
    .a_i    (a_i),
    .b_i    (b_i),
    .c_i    (c_i),
    .err_o  (err),
    .q_o    (q_o),
    .r_o    (r_o),
    .ovf_o  (ovf_o)
  );
endmodule

// File: rtl/qd_divider_chk.sv
module qd_divider_chk #(
  parameter int W = 64
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         out_valid_o,
  input logic         out_ready_i,
  input logic [W-1:0] q_o,
  input logic [W-1:0] r_o,
  input logic         ovf_o
);
  localparam int LW = $clog2(W + 2) + 1;
  localparam logic [LW-1:0] RUN_LAT = LW'(W + 1);

  logic [W-1:0]  a_cap, b_cap;
  logic [LW-1:0] lat_q;
  logic          acc;

  assign acc = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cap <= '0;
      b_cap <= '0;
      lat_q <= '0;
    end else begin
      if (acc) begin
        a_cap <= a_i;
        b_cap <= b_i;
        lat_q <= '0;
      end else if (!out_valid_o) begin
        lat_q <= lat_q + 1'b1;
      end
    end
  end

  p_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  p_err_val_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && ovf_o) |-> (q_o == '1 && r_o == '0));

  p_err_cond_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (ovf_o == ((b_cap == '0) || (a_cap >= b_cap))));

  p_rem_lt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !ovf_o) |-> (r_o < b_cap));

  p_err_lat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_valid_o) && ovf_o) |-> (lat_q == LW'(1)));

  p_run_lat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_valid_o) && !ovf_o) |-> (lat_q == RUN_LAT));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(q_o) && $stable(r_o) && $stable(ovf_o)));

  p_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i) |=> (!out_valid_o && in_ready_o));
endmodule

bind qd_divider qd_divider_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .a_i         (a_i),
  .b_i         (b_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .q_o         (q_o),
  .r_o         (r_o),
  .ovf_o       (ovf_o)
);

// File: tb/qd_divider_bench.sv
module qd_divider_bench;
  localparam int W = 64;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic         in_ready, out_valid, ovf;
  logic [W-1:0] q, r;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qd_divider #(.W(W)) u_qd_divider (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .a_i         (a),
    .b_i         (b),
    .c_i         (c),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .q_o         (q),
    .r_o         (r),
    .ovf_o       (ovf)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  // Issue one operation, wait for result, check it, then release it.
  task automatic run_op(input string tag, input logic [W-1:0] ai, bi, ci,
                        input int hold, input bit poke);
    logic [2*W-1:0] dvd, eq, er;
    logic           e_ovf;
    logic [W-1:0]   q0, r0;
    logic           o0;
    int             lat;
    dvd   = {ai, ci};
    e_ovf = (bi == '0) || (ai >= bi);
    if (!e_ovf) begin
      eq = dvd / {{W{1'b0}}, bi};
      er = dvd % {{W{1'b0}}, bi};
    end else begin
      eq = {{W{1'b0}}, {W{1'b1}}};
      er = '0;
    end
    @(negedge clk);
    chk({tag, " R2 in_ready before accept"}, W'(in_ready), W'(1));
    in_valid = 1'b1; a = ai; b = bi; c = ci;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R2 in_ready low when busy"}, W'(in_ready), W'(0));
    lat = 0;
    while (!out_valid && lat < 200) begin
      if (poke) begin
        in_valid = 1'b1; a = ~ai; b = 64'h3; c = ~ci;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && !out_valid) begin
        n_checks++;
        if (in_ready) begin
          n_err++;
          $display("FAIL %s R10: in_ready actual 1 expected 0", tag);
        end
      end
    end
    in_valid = 1'b0;
    if (e_ovf) chk({tag, " R7 error latency"}, W'(lat), W'(1));
    else       chk({tag, " R8 run latency"}, W'(lat), W'(W + 1));
    chk({tag, " R3/R4/R5 quotient"}, q, eq[W-1:0]);
    chk({tag, " R3/R4/R5 remainder"}, r, er[W-1:0]);
    chk({tag, " R6/R4 ovf"}, W'(ovf), W'(e_ovf));
    if (poke) chk({tag, " R10 result unchanged by poke"}, q, eq[W-1:0]);
    q0 = q; r0 = r; o0 = ovf;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R9 valid held"}, W'(out_valid), W'(1));
      chk({tag, " R9 q held"}, q, q0);
      chk({tag, " R9 r held"}, r, r0);
      chk({tag, " R9 ovf held"}, W'(ovf), W'(o0));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk({tag, " R12 valid drops"}, W'(out_valid), W'(0));
    chk({tag, " R12 ready returns"}, W'(in_ready), W'(1));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 in_ready after reset", W'(in_ready), W'(1));
    chk("R1 out_valid after reset", W'(out_valid), W'(0));
  endtask

  task automatic t_normal();
    run_op("R3 b=1", '0, 64'h1, 64'hDEAD_BEEF_0123_4567, 0, 0);
    run_op("R3 max quotient", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, '1, 0, 0);
    run_op("R3 all-ones divisor", 64'hFFFF_FFFF_FFFF_FFFE, '1, '1, 0, 0);
    run_op("R3 mid", 64'h0000_0012_3456_789A, 64'h0000_1000_0000_0003, 64'h5555_AAAA_1234_5678, 0, 0);
  endtask

  task automatic t_overflow();
    run_op("R4 a==b", 64'h1234, 64'h1234, 64'h99, 0, 0);
    run_op("R4 a>b", '1, 64'h7, 64'h1, 0, 0);
  endtask

  task automatic t_div_zero();
    run_op("R5 b=0 a=0", '0, '0, 64'h42, 0, 0);
    run_op("R5 b=0 a!=0", 64'h5, '0, '1, 0, 0);
  endtask

  task automatic t_backpressure();
    run_op("R9 hold normal", 64'h3, 64'h10, 64'hABCD, 3, 0);
    run_op("R9 hold error", 64'h20, 64'h10, 64'h0, 3, 0);
  endtask

  task automatic t_busy_ignore();
    run_op("R10 poke", 64'h1, 64'h2_0000_0001, 64'hFEED_FACE_CAFE_BABE, 0, 1);
  endtask

  task automatic t_inverse();
    for (int k = 0; k < 24; k++) begin
      logic [W-1:0]   qq, bb, rr;
      logic [2*W-1:0] prod;
      qq = {$urandom, $urandom};
      bb = (k % 2 == 0) ? {$urandom, $urandom} | 64'h1 : {32'h0, $urandom} | 64'h1;
      rr = {$urandom, $urandom} % bb;
      prod = {{W{1'b0}}, qq} * {{W{1'b0}}, bb} + {{W{1'b0}}, rr};
      run_op("R11 inverse", prod[2*W-1:W], bb, prod[W-1:0], 0, 0);
      chk("R11 quotient matches factor", q, qq);
      chk("R11 remainder matches addend", r, rr);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_normal();
    t_overflow();
    t_div_zero();
    t_backpressure();
    t_busy_ignore();
    t_inverse();
    finish_run();
  end
endmodule